// File: doc/BRIEF.md
# Multi-channel ultrasound transmit sequencer

This block drives a bank of high-voltage pulser channels from a stored transmit waveform. A pattern memory holds an ordered list of states. Each state carries a duration and a 3-bit level code for every channel. When the fire input is taken, every channel first counts out its own beamforming delay and then plays the states from index 0 up to a programmed last index. Each state is decoded into enables for four half-bridges (a positive side and a negative side per bridge), a ground clamp, and a shared isolation switch control.

A per-channel mode word selects 3-level operation, where a strength field sets how many bridges switch together, or 5-level operation, where the two bridge pairs serve two different supply amplitudes. The block enforces one cycle of all-off dead time when a channel reverses polarity directly. It keeps the isolation switch open for the whole burst, reports busy, and pulses done once every channel has finished. Configuration is written through a simple write port that is locked while a burst is running.

Top module: `utx_sequencer`

## Requirements
- R1: After reset every half-bridge enable, every clamp enable, busy, iso_open and done are 0, and all configuration holds zero: all codes 0, durations 0, delays 0, last index 0, and every channel in 3-level mode with strength 0.
- R2: When fire is sampled high at a clock edge E0 while busy is 0, channel c shows its state 0 drive from edge E0+d+1 onward, where d is that channel's delay value; before that its outputs are all off.
- R3: State s lasts dur[s]+1 cycles. States 0 up to the last index are played in order, after which the channel's outputs are all off.
- R4: Level codes: 0 is high impedance (all off), 1 is ground (clamp only), 2 and 4 are positive, 3 and 5 are negative, and 6 and 7 are treated as high impedance.
- R5: In 3-level mode, a positive or negative code switches the lowest-numbered bridges on the matching side: strength 0 selects bridges 0 to 3, strength 1 bridge 0, strength 2 bridges 0 and 1, strength 3 bridges 0 to 2. Codes 2 and 4 behave the same, as do codes 3 and 5.
- R6: In 5-level mode the strength field is ignored. Code 2 enables positive bridges 0 and 1, code 4 enables positive bridges 2 and 3, code 3 enables negative bridges 0 and 1, and code 5 enables negative bridges 2 and 3.
- R7: When a channel's drive would change directly from any positive enable to any negative enable, or the reverse, the outputs are all off for one cycle. That cycle replaces the first cycle of the new state.
- R8: A channel's clamp enable is never high in a cycle where any of its half-bridge enables is high.
- R9: busy and iso_open are high from edge E0 through the cycle before edge E0+D+P+1, where D is the largest channel delay and P is the sum of dur[s]+1 over the played states. done is high for exactly that one cycle, and busy falls in the same cycle. With busy low, no drive enable or clamp enable is high.
- R10: While busy is 1, configuration writes and fire are ignored. A write presented in the same cycle that fire is accepted is also ignored.
- R11: Write port: cfg_kind 0 sets code[row][chan] from data bits 2:0. Kind 1 sets dur[row]. Kind 2 sets delay[chan]. Kind 3 sets the mode of chan, with data bit 0 selecting 5-level operation and bits 2:1 the strength. Kind 4 sets the last state index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind being written (see R11) |
| cfg_row | input | ST_W | State index for code and duration writes |
| cfg_chan | input | CH_W | Channel index for code, delay and mode writes |
| cfg_data | input | CFG_W | Write data |
| fire | input | 1 | Starts a burst when idle |
| hb_pos | output | NCH*4 | Positive-side half-bridge enables, 4 per channel |
| hb_neg | output | NCH*4 | Negative-side half-bridge enables, 4 per channel |
| clamp_en | output | NCH | Ground clamp enable per channel |
| iso_open | output | 1 | Isolation switch held open during a burst |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse at the end of a burst |

## Verification
The bench builds the block with 4 channels, 4 states, 3-bit durations and 4-bit delays. This small size lets eight programmed configurations cover every level code on every channel in both modes and with all four strength values. It also covers every last-index value, durations from 1 to 4 cycles and reversals of polarity that need dead time. Each configuration is fired twice: once with a write and a second fire attempted mid-burst, and once without. The second burst shows at the outputs that the locked write never landed.

// File: rtl/utx_pkg.sv
`timescale 1ns/1ps
package utx_pkg;

    localparam logic [2:0] LV_HIZ   = 3'd0;
    localparam logic [2:0] LV_GND   = 3'd1;
    localparam logic [2:0] LV_POS_A = 3'd2;
    localparam logic [2:0] LV_NEG_A = 3'd3;
    localparam logic [2:0] LV_POS_B = 3'd4;
    localparam logic [2:0] LV_NEG_B = 3'd5;

    typedef enum logic [2:0] {
        CK_CODE  = 3'd0,
        CK_DUR   = 3'd1,
        CK_DELAY = 3'd2,
        CK_MODE  = 3'd3,
        CK_LAST  = 3'd4
    } cfg_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_PLAY = 2'd2,
        PH_FIN  = 2'd3
    } phase_e;

    typedef struct packed {
        logic       five;
        logic [1:0] strength;
    } chmode_t;

    typedef struct packed {
        logic [3:0] pos;
        logic [3:0] neg;
        logic       clamp;
    } drive_t;

    // Map one channel's level code to bridge and clamp enables.
    function automatic drive_t decode_level(input logic [2:0] code, input chmode_t m);
        drive_t     d;
        logic [3:0] grp;
        d = '0;
        if (m.five) begin
            case (code)
                LV_POS_A: d.pos   = 4'b0011;
                LV_POS_B: d.pos   = 4'b1100;
                LV_NEG_A: d.neg   = 4'b0011;
                LV_NEG_B: d.neg   = 4'b1100;
                LV_GND:   d.clamp = 1'b1;
                default:  d       = '0;
            endcase
        end else begin
            case (m.strength)
                2'd0:    grp = 4'b1111;
                2'd1:    grp = 4'b0001;
                2'd2:    grp = 4'b0011;
                default: grp = 4'b0111;
            endcase
            case (code)
                LV_POS_A, LV_POS_B: d.pos   = grp;
                LV_NEG_A, LV_NEG_B: d.neg   = grp;
                LV_GND:             d.clamp = 1'b1;
                default:            d       = '0;
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/utx_cfg_regs.sv
`timescale 1ns/1ps
module utx_cfg_regs
    import utx_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int NST   = 32,
    parameter int DUR_W = 8,
    parameter int DLY_W = 10,
    parameter int CFG_W = 10,
    localparam int ST_W = $clog2(NST),
    localparam int CH_W = $clog2(NCH)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [2:0]                         wr_kind,
    input  logic [ST_W-1:0]                    wr_row,
    input  logic [CH_W-1:0]                    wr_chan,
    input  logic [CFG_W-1:0]                   wr_data,
    output logic [NST-1:0][NCH-1:0][2:0]       codes_o,
    output logic [NST-1:0][DUR_W-1:0]          dur_o,
    output logic [NCH-1:0][DLY_W-1:0]          delay_o,
    output chmode_t [NCH-1:0]                  mode_o,
    output logic [ST_W-1:0]                    last_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            codes_o <= '0;
            dur_o   <= '0;
            delay_o <= '0;
            mode_o  <= '0;
            last_o  <= '0;
        end else if (wr_en) begin
            case (cfg_kind_e'(wr_kind))
                CK_CODE:  codes_o[wr_row][wr_chan] <= wr_data[2:0];
                CK_DUR:   dur_o[wr_row]            <= wr_data[DUR_W-1:0];
                CK_DELAY: delay_o[wr_chan]         <= wr_data[DLY_W-1:0];
                CK_MODE:  mode_o[wr_chan]          <= '{five: wr_data[0], strength: wr_data[2:1]};
                CK_LAST:  last_o                   <= wr_data[ST_W-1:0];
                default:  last_o                   <= last_o;
            endcase
        end
    end

endmodule

// File: rtl/utx_chan_seq.sv
`timescale 1ns/1ps
module utx_chan_seq
    import utx_pkg::*;
#(
    parameter int NST   = 32,
    parameter int DUR_W = 8,
    parameter int DLY_W = 10,
    localparam int ST_W  = $clog2(NST),
    localparam int CNT_W = (DLY_W > DUR_W) ? DLY_W : DUR_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [DLY_W-1:0]             delay_i,
    input  logic [ST_W-1:0]              last_i,
    input  logic [NST-1:0][DUR_W-1:0]    dur_tab_i,
    output phase_e                       phase_o,
    output logic [ST_W-1:0]              idx_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= PH_IDLE;
            idx_o   <= '0;
            cnt_q   <= '0;
        end else if (start_i) begin
            idx_o <= '0;
            if (delay_i == '0) begin
                phase_o <= PH_PLAY;
                cnt_q   <= CNT_W'(dur_tab_i[0]);
            end else begin
                phase_o <= PH_WAIT;
                cnt_q   <= CNT_W'(delay_i);
            end
        end else begin
            case (phase_o)
                PH_WAIT: begin
                    if (cnt_q == CNT_W'(1)) begin
                        phase_o <= PH_PLAY;
                        idx_o   <= '0;
                        cnt_q   <= CNT_W'(dur_tab_i[0]);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_PLAY: begin
                    if (cnt_q == '0) begin
                        if (idx_o == last_i) begin
                            phase_o <= PH_FIN;
                        end else begin
                            idx_o <= idx_o + 1'b1;
                            cnt_q <= CNT_W'(dur_tab_i[idx_o + 1'b1]);
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R3: playback never runs past the programmed last state
    p_idx_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_PLAY) |-> (idx_o <= last_i));

    // R2: a waiting channel's counter never sits at zero
    p_wait_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == PH_WAIT) |-> (cnt_q != '0));

endmodule

// File: rtl/utx_drive_stage.sv
`timescale 1ns/1ps
module utx_drive_stage
    import utx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active_i,
    input  logic [2:0] code_i,
    input  chmode_t    mode_i,
    output drive_t     drive_o
);

    drive_t nxt;
    logic   reversal;

    always_comb begin
        nxt      = active_i ? decode_level(code_i, mode_i) : '0;
        reversal = ((|nxt.pos) && (|drive_o.neg)) || ((|nxt.neg) && (|drive_o.pos));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_o <= '0;
        end else if (reversal) begin
            drive_o <= '0;
        end else begin
            drive_o <= nxt;
        end
    end

    // R8: clamp and bridges are mutually exclusive
    p_clamp_excl_r8: assert property (@(posedge clk) disable iff (rst)
        drive_o.clamp |-> (drive_o.pos == '0 && drive_o.neg == '0));

    // R7: negative drive never directly follows positive drive
    p_dead_time_pn_r7: assert property (@(posedge clk) disable iff (rst)
        (|drive_o.neg) |-> !$past(|drive_o.pos));

    // R7: positive drive never directly follows negative drive
    p_dead_time_np_r7: assert property (@(posedge clk) disable iff (rst)
        (|drive_o.pos) |-> !$past(|drive_o.neg));

endmodule

// File: rtl/utx_sequencer.sv
`timescale 1ns/1ps
module utx_sequencer
    import utx_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int NST   = 32,
    parameter int DUR_W = 8,
    parameter int DLY_W = 10,
    localparam int ST_W  = $clog2(NST),
    localparam int CH_W  = $clog2(NCH),
    localparam int W_A   = (DLY_W > DUR_W) ? DLY_W : DUR_W,
    localparam int W_B   = (ST_W > 3) ? ST_W : 3,
    localparam int CFG_W = (W_A > W_B) ? W_A : W_B
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_kind,
    input  logic [ST_W-1:0]      cfg_row,
    input  logic [CH_W-1:0]      cfg_chan,
    input  logic [CFG_W-1:0]     cfg_data,
    input  logic                 fire,
    output logic [NCH*4-1:0]     hb_pos,
    output logic [NCH*4-1:0]     hb_neg,
    output logic [NCH-1:0]       clamp_en,
    output logic                 iso_open,
    output logic                 busy,
    output logic                 done
);

    logic [NST-1:0][NCH-1:0][2:0] codes_w;
    logic [NST-1:0][DUR_W-1:0]    dur_w;
    logic [NCH-1:0][DLY_W-1:0]    delay_w;
    chmode_t [NCH-1:0]            mode_w;
    logic [ST_W-1:0]              last_w;

    logic             busy_q;
    logic             done_q;
    logic             start;
    logic             wr_ok;
    logic [NCH-1:0]   fin_vec;

    phase_e           phase_w [NCH];
    logic [ST_W-1:0]  idx_w   [NCH];
    drive_t           drv_w   [NCH];

    assign start = fire && !busy_q;
    assign wr_ok = cfg_we && !busy_q && !fire;

    utx_cfg_regs #(
        .NCH(NCH), .NST(NST), .DUR_W(DUR_W), .DLY_W(DLY_W), .CFG_W(CFG_W)
    ) cfg_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_ok), .wr_kind(cfg_kind), .wr_row(cfg_row),
        .wr_chan(cfg_chan), .wr_data(cfg_data),
        .codes_o(codes_w), .dur_o(dur_w), .delay_o(delay_w),
        .mode_o(mode_w), .last_o(last_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        utx_chan_seq #(
            .NST(NST), .DUR_W(DUR_W), .DLY_W(DLY_W)
        ) seq_i (
            .clk(clk), .rst(rst), .start_i(start),
            .delay_i(delay_w[c]), .last_i(last_w), .dur_tab_i(dur_w),
            .phase_o(phase_w[c]), .idx_o(idx_w[c])
        );

        utx_drive_stage drv_i (
            .clk(clk), .rst(rst),
            .active_i(phase_w[c] == PH_PLAY),
            .code_i(codes_w[idx_w[c]][c]),
            .mode_i(mode_w[c]),
            .drive_o(drv_w[c])
        );

        assign fin_vec[c]          = (phase_w[c] == PH_FIN);
        assign hb_pos[c*4 +: 4]    = drv_w[c].pos;
        assign hb_neg[c*4 +: 4]    = drv_w[c].neg;
        assign clamp_en[c]         = drv_w[c].clamp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
            end else if (busy_q && (&fin_vec)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign iso_open = busy_q;

    // R10: configuration is frozen across a write attempted during a burst
    p_cfg_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cfg_we) |=> ($stable(delay_w) && $stable(codes_w) &&
                                $stable(dur_w) && $stable(mode_w) && $stable(last_w)));

    // R9: done lasts a single cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: done marks the fall of busy
    p_done_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));

    // R9: nothing drives while idle
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (hb_pos == '0 && hb_neg == '0 && clamp_en == '0));

endmodule

// File: tb/utx_sequencer_tb.sv
`timescale 1ns/1ps
module utx_sequencer_tb_top;

    localparam int NCH = 4;
    localparam int NST = 4;
    localparam int DUR_W = 3;
    localparam int DLY_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_kind = '0;
    logic [1:0]  cfg_row = '0;
    logic [1:0]  cfg_chan = '0;
    logic [3:0]  cfg_data = '0;
    logic        fire = 1'b0;
    logic [15:0] hb_pos;
    logic [15:0] hb_neg;
    logic [3:0]  clamp_en;
    logic        iso_open;
    logic        busy;
    logic        done;

    int total = 0;
    int bad   = 0;

    int codes_m [NST][NCH];
    int dur_m   [NST];
    int dly_m   [NCH];
    int five_m  [NCH];
    int str_m   [NCH];
    int last_m;

    always #2 clk = ~clk;

    utx_sequencer #(
        .NCH(NCH), .NST(NST), .DUR_W(DUR_W), .DLY_W(DLY_W)
    ) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_row(cfg_row), .cfg_chan(cfg_chan), .cfg_data(cfg_data),
        .fire(fire), .hb_pos(hb_pos), .hb_neg(hb_neg), .clamp_en(clamp_en),
        .iso_open(iso_open), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input int kind, input int row, input int chan, input int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_kind = 3'(kind);
        cfg_row  = 2'(row);
        cfg_chan = 2'(chan);
        cfg_data = 4'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected {pos,neg,clamp} from R4, R5, R6
    function automatic logic [8:0] exp_drive(input int code, input int five, input int str);
        logic [3:0] grp;
        logic [3:0] p;
        logic [3:0] n;
        logic       cl;
        p = 4'b0; n = 4'b0; cl = 1'b0;
        if (five != 0) begin
            if (code == 2) p = 4'b0011;
            if (code == 4) p = 4'b1100;
            if (code == 3) n = 4'b0011;
            if (code == 5) n = 4'b1100;
        end else begin
            grp = (str == 0) ? 4'b1111 : 4'((1 << str) - 1);
            if (code == 2 || code == 4) p = grp;
            if (code == 3 || code == 5) n = grp;
        end
        if (code == 1) cl = 1'b1;
        return {p, n, cl};
    endfunction

    // R11: program one configuration through the write port
    task automatic program_cfg(input int r);
        for (int s = 0; s < NST; s++) begin
            for (int c = 0; c < NCH; c++) begin
                codes_m[s][c] = (s * 3 + c + r) % 8;
                wr(0, s, c, codes_m[s][c]);
            end
            dur_m[s] = (s + r) % 4;
            wr(1, s, 0, dur_m[s]);
        end
        for (int c = 0; c < NCH; c++) begin
            dly_m[c]  = (c == NCH - 1) ? (3 + r % 8) : ((c * 5 + r * 3) % 16);
            five_m[c] = (c + r) % 2;
            str_m[c]  = (c + r / 2) % 4;
            wr(2, 0, c, dly_m[c]);
            wr(3, 0, c, (str_m[c] << 1) | five_m[c]);
        end
        last_m = r % 4;
        wr(4, 0, 0, last_m);
    endtask

    task automatic run_burst(input bit intrude);
        int ptot;
        int maxd;
        logic [3:0] prev_p [NCH];
        logic [3:0] prev_n [NCH];
        ptot = 0;
        maxd = 0;
        for (int s = 0; s <= last_m; s++) ptot += dur_m[s] + 1;
        for (int c = 0; c < NCH; c++) begin
            if (dly_m[c] > maxd) maxd = dly_m[c];
            prev_p[c] = 4'b0;
            prev_n[c] = 4'b0;
        end
        @(negedge clk);
        fire = 1'b1;
        for (int n = 0; n <= maxd + ptot + 2; n++) begin
            logic [15:0] ep;
            logic [15:0] en;
            logic [3:0]  ec;
            logic        excl_ok;
            @(negedge clk);
            if (n == 0) fire = 1'b0;
            ep = '0; en = '0; ec = '0;
            for (int c = 0; c < NCH; c++) begin
                int k;
                logic [8:0] d;
                d = 9'b0;
                k = n - 1 - dly_m[c];
                if (k >= 0 && k < ptot) begin
                    int acc;
                    int sidx;
                    acc = 0;
                    sidx = 0;
                    for (int s = 0; s <= last_m; s++) begin
                        if (k >= acc) sidx = s;
                        acc += dur_m[s] + 1;
                    end
                    d = exp_drive(codes_m[sidx][c], five_m[c], str_m[c]);
                end
                // R7 dead time on direct reversal
                if ((d[8:5] != 0 && prev_n[c] != 0) || (d[4:1] != 0 && prev_p[c] != 0)) d = 9'b0;
                prev_p[c] = d[8:5];
                prev_n[c] = d[4:1];
                ep[c*4 +: 4] = d[8:5];
                en[c*4 +: 4] = d[4:1];
                ec[c]        = d[0];
            end
            chk(hb_pos == ep && hb_neg == en && clamp_en == ec,
                "R2 R3 R4 R5 R6 R7 R11 drive", {hb_pos, hb_neg, clamp_en}, {ep, en, ec});
            excl_ok = 1'b1;
            for (int c = 0; c < NCH; c++)
                if (clamp_en[c] && (hb_pos[c*4 +: 4] != 0 || hb_neg[c*4 +: 4] != 0)) excl_ok = 1'b0;
            chk(excl_ok, "R8 clamp exclusive", {hb_pos, hb_neg, clamp_en}, 64'h0);
            chk(busy == (n <= maxd + ptot) && iso_open == (n <= maxd + ptot) &&
                done == (n == maxd + ptot + 1),
                "R9 busy iso done", {busy, iso_open, done},
                {(n <= maxd + ptot), (n <= maxd + ptot), (n == maxd + ptot + 1)});
            // R10: write and fire attempted mid-burst must be ignored
            if (intrude && n == 1) begin
                cfg_we = 1'b1; cfg_kind = 3'd2; cfg_chan = 2'd0; cfg_data = 4'd13;
                fire = 1'b1;
            end
            if (intrude && n == 2) begin
                cfg_we = 1'b0;
                fire = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(hb_pos == 0 && hb_neg == 0 && clamp_en == 0, "R1 drive reset",
            {hb_pos, hb_neg, clamp_en}, 64'h0);
        chk(!busy && !iso_open && !done, "R1 status reset", {busy, iso_open, done}, 64'h0);
        // R1: zero config gives one 1-cycle high-impedance state at delay 0
        for (int c = 0; c < NCH; c++) begin
            dly_m[c] = 0; five_m[c] = 0; str_m[c] = 0;
            for (int s = 0; s < NST; s++) codes_m[s][c] = 0;
        end
        for (int s = 0; s < NST; s++) dur_m[s] = 0;
        last_m = 0;
        run_burst(1'b0);
        for (int r = 0; r < 8; r++) begin
            program_cfg(r);
            run_burst(1'b1);
            run_burst(1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule